// File: doc/BRIEF.md
# Real-Time Clock with Alarms

This block keeps wall time for a chip from a slow 32.768 kHz tick that arrives as a one-cycle enable on the system clock. A fractional accumulator turns the tick into millisecond steps. A millisecond counter runs from 0 to 999, and each time it wraps a seconds counter advances. Software reaches the clock through a plain 32-bit register bus with a combinational read path. A single level interrupt output carries every alarm that software has unmasked.

Software never reads the counters directly. After every eight ticks the block copies both counters to bus-visible registers, and a busy flag marks the tick interval that ends with this copy. Reading the milliseconds register also latches the copied seconds into a shadow register, so software can read a coherent pair. A write that arrives while the busy flag is up is held back. It takes effect at the edge that closes the busy window.

There are five alarm sources: two seconds-compare alarms, a milliseconds-compare alarm, a seconds countdown and a milliseconds countdown. Each source has one bit in a mask register and one bit in a write-one-to-clear status register.

Top module: `rtc_alarm_top`

## Requirements
- R1: Each tick adds 1000 to a fractional accumulator that starts at 0. When the sum reaches TICK_HZ, TICK_HZ is subtracted and the live millisecond counter advances by one. From 999 the counter goes to 0, and at that step the live seconds counter increments modulo 2^32.
- R2: Offset 0x004 bit 0 is the busy flag. Ticks are counted from reset. The flag reads 1 from the clock after tick 8k+7 up to and including the clock of tick 8k+8, and reads 0 at all other times. All other bits of 0x004 read 0.
- R3: On the clock of tick 8k+8, offset 0x008 (seconds) and offset 0x010 (milliseconds) take the live counter values held just before that edge. Between these copies they do not change.
- R4: A read of 0x010 loads the shadow register at 0x00C with the seconds value that 0x008 returned in that same cycle.
- R5: A write issued while busy reads 1 is not applied at once. One held slot keeps the newest such write, and an earlier held write is dropped. The held write, or a write issued on the closing clock itself, is applied on the clock of tick 8k+8.
- R6: Status (0x02C) is write-one-to-clear over bits 4:0. A 0 bit leaves its status bit unchanged. An event in the same cycle as a clear wins, and the bit stays set.
- R7: irq_o is 1 exactly when some bit of status AND mask is 1.
- R8: Seconds alarms 0 and 1 (0x014, 0x018, status bits 0 and 1) set their bit when a millisecond wrap advances the live seconds counter to a value equal to the alarm. A software write to 0x008 loads the live seconds counter and never raises these bits. A write and a wrap in the same cycle leave the written value.
- R9: Status bit 2 is set when a millisecond step moves the live millisecond counter to the value in 0x01C.
- R10: Offset 0x024 is the millisecond countdown. Bit 31 is the enable and bits 27:0 hold the count, and it reads back as {enable, 3'b000, count}. While enabled it drops by one per millisecond step. A step taken while the count is 1 or 0 sets status bit 4 and clears the whole register. A write loads the register, so writing 0 disarms it. A write and a step in the same cycle leave the written value.
- R11: Offset 0x020 is a seconds countdown with the same layout and rules as R10. It steps on each seconds increment caused by a millisecond wrap and sets status bit 3.
- R12: After reset every register reads 0, the accumulator and tick count are 0, and irq_o is 0.
- R13: The mask (0x028) holds bits 4:0, and its other bits read 0. Any offset not listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz period |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read request, 0 otherwise |
| irq_o | output | 1 | Level interrupt: OR over status AND mask |

## Verification
The bench stops the tick inside a busy window and issues two writes to one register and one to another. A design without a held slot would apply the first write at once, and one with a queue instead of a newest-wins slot would let the dropped write through. It writes the seconds counter to a value that equals an armed alarm. A level comparator would raise the alarm at that point, while an edge-on-advance design stays quiet. It also disarms a countdown by writing zero, writes zero to status, and lets the countdowns expire at count 1. An off-by-one in the expiry rule shows up as a wrong cycle for the countdown interrupt or a stale enable bit. A non-integer tick rate is used so that an accumulator that drops the remainder drifts away from the reference.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned IRQ_N  = 5;

  localparam logic [ADDR_W-1:0] A_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] A_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] A_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] A_MSEC   = 8'h10;
  localparam logic [ADDR_W-1:0] A_SA0    = 8'h14;
  localparam logic [ADDR_W-1:0] A_SA1    = 8'h18;
  localparam logic [ADDR_W-1:0] A_MA0    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_CD_S   = 8'h20;
  localparam logic [ADDR_W-1:0] A_CD_MS  = 8'h24;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h2C;

  localparam int unsigned IB_MS_ALARM = 2;
  localparam int unsigned IB_CD_BASE  = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
  } bus_wr_t;
endpackage

// File: rtl/rtc_ms_tick.sv
module rtc_ms_tick #(
  parameter int unsigned TICK_HZ    = 32768,
  parameter int unsigned MS_PER_SEC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic ms_step_o
);
  localparam int unsigned ACC_W = $clog2(TICK_HZ + MS_PER_SEC);

  logic [ACC_W-1:0] acc_q, acc_sum;

  always_comb begin
    acc_sum   = acc_q + ACC_W'(MS_PER_SEC);
    ms_step_o = tick_i && (acc_sum >= ACC_W'(TICK_HZ));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= ms_step_o ? acc_sum - ACC_W'(TICK_HZ) : acc_sum;
  end
endmodule

// File: rtl/rtc_copy_window.sv
module rtc_copy_window #(
  parameter int unsigned COPY_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic busy_o,
  output logic close_o
);
  localparam int unsigned PH_W = (COPY_TICKS > 2) ? $clog2(COPY_TICKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(COPY_TICKS - 1);

  logic [PH_W-1:0] phase_q;

  assign busy_o  = (phase_q == PH_LAST);
  assign close_o = tick_i && busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_i) phase_q <= busy_o ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/rtc_countdown.sv
module rtc_countdown #(
  parameter int unsigned CD_W   = 28,
  parameter int unsigned EN_BIT = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic        load_i,
  input  logic [31:0] load_data_i,
  output logic        fire_o,
  output logic [31:0] word_o
);
  logic            en_q;
  logic [CD_W-1:0] val_q;
  logic            last;
  logic            unused_bits;

  assign unused_bits = ^load_data_i[EN_BIT-1:CD_W];
  assign last   = (val_q <= CD_W'(1));
  assign fire_o = step_i && en_q && !load_i && last;

  always_comb begin
    word_o            = '0;
    word_o[EN_BIT]    = en_q;
    word_o[CD_W-1:0]  = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      val_q <= '0;
    end else if (load_i) begin
      en_q  <= load_data_i[EN_BIT];
      val_q <= load_data_i[CD_W-1:0];
    end else if (step_i && en_q) begin
      if (last) begin
        en_q  <= 1'b0;
        val_q <= '0;
      end else begin
        val_q <= val_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_HZ    = 32768,
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned COPY_TICKS = 8,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned CD_W       = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned MS_W = $clog2(MS_PER_SEC);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic ms_step, busy, close;

  rtc_ms_tick #(.TICK_HZ(TICK_HZ), .MS_PER_SEC(MS_PER_SEC)) u_ms_tick (
    .clk_i, .rst_ni, .tick_i, .ms_step_o(ms_step)
  );

  rtc_copy_window #(.COPY_TICKS(COPY_TICKS)) u_window (
    .clk_i, .rst_ni, .tick_i, .busy_o(busy), .close_o(close)
  );

  // held write slot: newest write of a busy window wins
  logic    hold_v;
  bus_wr_t hold_q;
  logic    wr_req, wr_now, wr_hold, eff_v;
  bus_wr_t eff;

  assign wr_req  = req_i && we_i;
  assign wr_now  = wr_req && !busy;
  assign wr_hold = wr_req && busy;
  assign eff_v   = wr_now || (close && (wr_hold || hold_v));
  assign eff     = wr_req ? '{addr: addr_i, data: wdata_i} : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else if (close) begin
      hold_v <= 1'b0;
    end else if (wr_hold) begin
      hold_v <= 1'b1;
      hold_q <= '{addr: addr_i, data: wdata_i};
    end
  end

  logic wr_sec, wr_ma, wr_mask, wr_stat;
  logic [1:0] wr_sa;

  always_comb begin
    wr_sec   = eff_v && (eff.addr == A_SEC);
    wr_sa[0] = eff_v && (eff.addr == A_SA0);
    wr_sa[1] = eff_v && (eff.addr == A_SA1);
    wr_ma    = eff_v && (eff.addr == A_MA0);
    wr_mask  = eff_v && (eff.addr == A_MASK);
    wr_stat  = eff_v && (eff.addr == A_STAT);
  end

  // live counters
  logic [MS_W-1:0]  ms_q, ms_next;
  logic [SEC_W-1:0] sec_q, sec_inc;
  logic             ms_last, sec_wrap;

  assign ms_last  = (ms_q == MS_LAST);
  assign sec_wrap = ms_step && ms_last;
  assign ms_next  = ms_last ? '0 : ms_q + 1'b1;
  assign sec_inc  = sec_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      if (ms_step) ms_q <= ms_next;
      if (wr_sec)        sec_q <= eff.data[SEC_W-1:0];
      else if (sec_wrap) sec_q <= sec_inc;
    end
  end

  // bus-visible copies and shadow
  logic [MS_W-1:0]  vis_ms_q;
  logic [SEC_W-1:0] vis_sec_q, shd_q;
  logic             rd_req;

  assign rd_req = req_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_ms_q  <= '0;
      vis_sec_q <= '0;
      shd_q     <= '0;
    end else begin
      if (close) begin
        vis_ms_q  <= ms_q;
        vis_sec_q <= sec_q;
      end
      if (rd_req && addr_i == A_MSEC) shd_q <= vis_sec_q;
    end
  end

  // alarm compare registers
  logic [1:0][SEC_W-1:0] sa_q;
  logic [31:0]           ma_q;
  logic [IRQ_N-1:0]      mask_q, status_q, ev, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q   <= '0;
      ma_q   <= '0;
      mask_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++)
        if (wr_sa[i]) sa_q[i] <= eff.data[SEC_W-1:0];
      if (wr_ma)   ma_q   <= eff.data;
      if (wr_mask) mask_q <= eff.data[IRQ_N-1:0];
    end
  end

  // countdowns: index 0 steps per second, index 1 per millisecond
  logic [1:0]       cd_fire, cd_step, cd_load;
  logic [1:0][31:0] cd_word;

  assign cd_step = {ms_step, sec_wrap};

  for (genvar g = 0; g < 2; g++) begin : g_cd
    assign cd_load[g] = eff_v && (eff.addr == A_CD_S + ADDR_W'(4 * g));
    rtc_countdown #(.CD_W(CD_W)) u_cd (
      .clk_i,
      .rst_ni,
      .step_i     (cd_step[g]),
      .load_i     (cd_load[g]),
      .load_data_i(eff.data),
      .fire_o     (cd_fire[g]),
      .word_o     (cd_word[g])
    );
  end

  always_comb begin
    ev = '0;
    for (int i = 0; i < 2; i++)
      ev[i] = sec_wrap && !wr_sec && (sec_inc == sa_q[i]);
    ev[IB_MS_ALARM] = ms_step && (32'(ms_next) == ma_q);
    ev[IB_CD_BASE +: 2] = cd_fire;
    clr = wr_stat ? eff.data[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | ev;
  end

  assign irq_o = |(status_q & mask_q);

  always_comb begin
    rdata_o = '0;
    if (rd_req) begin
      unique case (addr_i)
        A_BUSY:   rdata_o = 32'(busy);
        A_SEC:    rdata_o = 32'(vis_sec_q);
        A_SHADOW: rdata_o = 32'(shd_q);
        A_MSEC:   rdata_o = 32'(vis_ms_q);
        A_SA0:    rdata_o = 32'(sa_q[0]);
        A_SA1:    rdata_o = 32'(sa_q[1]);
        A_MA0:    rdata_o = ma_q;
        A_CD_S:   rdata_o = cd_word[0];
        A_CD_MS:  rdata_o = cd_word[1];
        A_MASK:   rdata_o = 32'(mask_q);
        A_STAT:   rdata_o = 32'(status_q);
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

module rtc_alarm_chk #(
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned MS_W       = 10,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned CD_W       = 28
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             req_i,
  input logic             we_i,
  input logic             busy_i,
  input logic             close_i,
  input logic             hold_v_i,
  input logic [MS_W-1:0]  ms_i,
  input logic [SEC_W-1:0] vis_sec_i,
  input logic [4:0]       status_i,
  input logic [31:0]      cdm_i
);
  assert_ms_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ms_i) < MS_PER_SEC);

  assert_busy_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(busy_i));

  assert_copy_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_i |=> $stable(vis_sec_i));

  assert_hold_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !hold_v_i);

  assert_clear_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i) && !hold_v_i) |=> ((~status_i & $past(status_i)) == 5'b0));

  assert_cd_no_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdm_i[31] && !(req_i && we_i) && !hold_v_i) |=> (cdm_i[CD_W-1:0] <= $past(cdm_i[CD_W-1:0])));
endmodule

bind rtc_alarm_top rtc_alarm_chk #(
  .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W), .SEC_W(SEC_W), .CD_W(CD_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .busy_i    (busy),
  .close_i   (close),
  .hold_v_i  (hold_v),
  .ms_i      (ms_q),
  .vis_sec_i (vis_sec_q),
  .status_i  (status_q),
  .cdm_i     (cd_word[1])
);

// File: tb/sim_rtc_alarm_top.sv
`timescale 1ns/1ps
module sim_rtc_alarm_top;
  localparam int unsigned HZ = 2500;

  logic        clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  rtc_alarm_top #(.TICK_HZ(HZ)) u0 (
    .clk_i(clk), .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  int checks = 0, fails = 0;
  bit running = 0, tick_en = 0, done = 0;

  // behavioural reference state
  int unsigned acc_m, ph_m;
  bit [31:0] ms_m, sec_m, vsec_m, vms_m, shd_m, sa0_m, sa1_m, ma0_m, cds_m, cdm_m, mask_m, st_m, hd_m;
  bit        hv_m;
  bit [7:0]  ha_m;

  function automatic bit [31:0] cd_load(bit [31:0] d);
    return {d[31], 3'b000, d[27:0]};
  endfunction

  function automatic bit [31:0] cd_run(bit [31:0] w, bit step, output bit fire);
    fire = 0;
    if (step && w[31]) begin
      if (w[27:0] <= 1) begin w = 0; fire = 1; end
      else w = w - 1;
    end
    return w;
  endfunction

  function automatic bit [31:0] model_read(bit [7:0] a);
    case (a)
      8'h04: return {31'b0, ph_m == 7};
      8'h08: return vsec_m;
      8'h0C: return shd_m;
      8'h10: return vms_m;
      8'h14: return sa0_m;
      8'h18: return sa1_m;
      8'h1C: return ma0_m;
      8'h20: return cds_m;
      8'h24: return cdm_m;
      8'h28: return {27'b0, mask_m[4:0]};
      8'h2C: return {27'b0, st_m[4:0]};
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit busy, close, step, wrap, wreq, ev_v, f3, f4;
    bit [7:0] ea;
    bit [31:0] ed, n_sec, n_ms, n_cds, n_cdm, e;
    int unsigned a;
    busy = (ph_m == 7);
    close = tick_i && busy;
    step = 0;
    a = acc_m;
    if (tick_i) begin
      a = a + 1000;
      if (a >= HZ) begin a = a - HZ; step = 1; end
    end
    wrap = step && (ms_m == 999);
    wreq = req_i && we_i;
    ev_v = 0; ea = 0; ed = 0;
    if (wreq && !busy) begin ev_v = 1; ea = addr_i; ed = wdata_i; end
    else if (close && wreq) begin ev_v = 1; ea = addr_i; ed = wdata_i; end
    else if (close && hv_m) begin ev_v = 1; ea = ha_m; ed = hd_m; end
    e = 0;
    n_sec = sec_m;
    if (ev_v && ea == 8'h08) n_sec = ed;
    else if (wrap) begin
      n_sec = sec_m + 1;
      if (sec_m + 32'd1 == sa0_m) e[0] = 1;
      if (sec_m + 32'd1 == sa1_m) e[1] = 1;
    end
    n_ms = step ? ((ms_m == 999) ? 0 : ms_m + 1) : ms_m;
    if (step && n_ms == ma0_m) e[2] = 1;
    f3 = 0; f4 = 0;
    if (ev_v && ea == 8'h20) n_cds = cd_load(ed); else n_cds = cd_run(cds_m, wrap, f3);
    if (ev_v && ea == 8'h24) n_cdm = cd_load(ed); else n_cdm = cd_run(cdm_m, step, f4);
    e[3] = f3; e[4] = f4;
    st_m = (st_m & ~((ev_v && ea == 8'h2C) ? {27'b0, ed[4:0]} : 32'b0)) | e;
    if (ev_v && ea == 8'h28) mask_m = {27'b0, ed[4:0]};
    if (ev_v && ea == 8'h14) sa0_m = ed;
    if (ev_v && ea == 8'h18) sa1_m = ed;
    if (ev_v && ea == 8'h1C) ma0_m = ed;
    if (req_i && !we_i && addr_i == 8'h10) shd_m = vsec_m;
    if (close) begin vsec_m = sec_m; vms_m = ms_m; end
    if (close) hv_m = 0;
    else if (wreq && busy) begin hv_m = 1; ha_m = addr_i; hd_m = wdata_i; end
    if (tick_i) ph_m = (ph_m == 7) ? 0 : ph_m + 1;
    acc_m = a; sec_m = n_sec; ms_m = n_ms; cds_m = n_cds; cdm_m = n_cdm;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_m = 0; ph_m = 0; ms_m = 0; sec_m = 0; vsec_m = 0; vms_m = 0; shd_m = 0;
      sa0_m = 0; sa1_m = 0; ma0_m = 0; cds_m = 0; cdm_m = 0; mask_m = 0; st_m = 0;
      hv_m = 0; ha_m = 0; hd_m = 0;
    end else model_step();
  end

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // interrupt compared with the reference on every clock
  always @(negedge clk) begin
    if (rst_ni && running)
      chk("R7 irq level", {31'b0, irq_o}, {31'b0, |(st_m[4:0] & mask_m[4:0])});
  end

  initial begin
    int unsigned tcnt = 0;
    forever begin
      @(negedge clk);
      #0.5;
      tcnt++;
      tick_i = tick_en && (tcnt % 4 != 3);
    end
  end

  task automatic bus_write(bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_read(bit [7:0] a, string tag, output bit [31:0] v);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    #1;
    v = rdata_o;
    chk(tag, rdata_o, model_read(a));
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit [31:0] v, old_sa0, old_sa1;
    bit [7:0] regs [12] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};
    idle(3);
    rst_ni = 1;
    running = 1;
    // R12: reset values with the tick held off
    foreach (regs[i]) begin
      bus_read(regs[i], "R12 reset value", v);
      chk("R12 reset literal", v, 32'h0);
    end
    chk("R12 irq after reset", {31'b0, irq_o}, 32'h0);
    tick_en = 1;

    // R13: mask width and unmapped offset
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_read(8'h28, "R13 mask readback", v);
    chk("R13 mask literal", v, 32'h1F);
    bus_read(8'h30, "R13 unmapped", v);
    chk("R13 unmapped literal", v, 32'h0);

    // R2: busy flag through several windows
    for (int i = 0; i < 40; i++) bus_read(8'h04, "R2 busy flag", v);

    // R1 / R3: copied counters
    idle(300);
    bus_read(8'h10, "R1 R3 msec copy", v);
    bus_read(8'h08, "R3 sec copy", v);

    // R4: shadow
    bus_read(8'h10, "R4 msec read", v);
    bus_read(8'h0C, "R4 shadow", v);

    // R9: millisecond alarm
    bus_read(8'h10, "R3 msec copy", v);
    bus_write(8'h1C, (v + 30) % 1000);
    idle(200);
    bus_read(8'h2C, "R9 ms alarm status", v);
    bus_write(8'h2C, 32'h0);
    bus_read(8'h2C, "R6 zero write keeps", v);
    bus_write(8'h2C, 32'h4);
    bus_read(8'h2C, "R6 w1c clear", v);

    // R10: millisecond countdown expiry and disarm
    bus_write(8'h24, 32'h8000_000A);
    idle(8);
    bus_read(8'h24, "R10 countdown running", v);
    idle(80);
    bus_read(8'h24, "R10 countdown expired", v);
    bus_read(8'h2C, "R10 countdown status", v);
    bus_write(8'h2C, 32'h1F);
    bus_write(8'h24, 32'h8000_0005);
    bus_write(8'h24, 32'h0);
    idle(60);
    bus_read(8'h2C, "R10 disarm status", v);
    bus_read(8'h24, "R10 disarm word", v);

    // R8 / R11: seconds alarms and seconds countdown
    bus_write(8'h2C, 32'h1F);
    bus_write(8'h08, 32'd100);
    bus_write(8'h14, 32'd101);
    bus_write(8'h18, 32'd102);
    bus_write(8'h20, 32'h8000_0002);
    idle(2000);
    bus_read(8'h20, "R11 sec countdown mid", v);
    idle(6500);
    bus_read(8'h2C, "R8 R11 status", v);
    bus_read(8'h20, "R11 sec countdown done", v);
    bus_read(8'h08, "R3 sec copy", v);

    // R8: write onto the alarm value raises nothing
    bus_write(8'h2C, 32'h1F);
    bus_write(8'h18, 32'd500);
    bus_write(8'h08, 32'd500);
    idle(30);
    bus_read(8'h2C, "R8 write no alarm", v);

    // R5: held writes, newest wins
    bus_read(8'h14, "R5 pre", old_sa0);
    bus_read(8'h18, "R5 pre", old_sa1);
    while (ph_m != 7) @(negedge clk);
    tick_en = 0;
    idle(4);
    bus_write(8'h14, 32'd1111);
    bus_read(8'h14, "R5 held not applied", v);
    chk("R5 held literal", v, old_sa0);
    bus_write(8'h14, 32'd2222);
    bus_write(8'h18, 32'd3333);
    bus_read(8'h18, "R5 held other", v);
    chk("R5 held other literal", v, old_sa1);
    tick_en = 1;
    idle(12);
    bus_read(8'h14, "R5 dropped write", v);
    chk("R5 dropped literal", v, old_sa0);
    bus_read(8'h18, "R5 applied write", v);
    chk("R5 applied literal", v, 32'd3333);

    idle(20);
    running = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule